// File: doc/BRIEF.md
# Six-Bit GPIO Port with Peripheral Pin Override

This block is a memory-mapped general-purpose I/O port of one byte-wide register window. Five pins are bidirectional and a sixth is input-only. Software owns an output data latch and a direction register. Writes to either the latch address or the port address land in the latch. A read of the latch address returns the stored latch. A read of the port address returns the live pin levels after a two-flop synchronizer.

Each bidirectional pin also has a peripheral path. When a peripheral has selected a pin, it can either force the pin to drive its own data or force the pin to act as an input. Neither override is ever written into the direction register, so software read-modify-write of that register stays safe. The sixth pin is steered by a configuration input. It is either the active-low master reset input or a plain readable input.

Top module: `gpio_port`

## Requirements
- R1: With no peripheral selected, a direction bit of 1 turns that pin's output enable off, and a direction bit of 0 drives the latch bit onto the pin. Pad outputs are registered and change on the second clock edge after the register write.
- R2: A synchronous reset sets all five direction bits to 1, the latch to 0, every pad output enable to 0 and the read data to 0.
- R3: A write to address 1 (latch) or to address 0 (port) loads bits 4:0 of the write data into the latch. A read of address 1 returns the latch in bits 4:0.
- R4: Pin inputs pass through two flops. A level applied between two edges appears on `pin_sync` after the second of those edges, not after the first. A read of address 0 returns that synchronized level in bits 5:0.
- R5: Peripheral select, enable, data and force-input signals never change the direction register as read at address 2.
- R6: A pin whose peripheral select and peripheral output enable are both 1 is driven, with the peripheral data, whatever its direction bit is. This case takes priority over force-input.
- R7: A peripheral output enable has no effect on its pin while that pin's select is 0.
- R8: A pin whose select and force-input are both 1, and whose peripheral output enable is 0, has its output enable off even when its direction bit is 0.
- R9: Direction writes use address 2. Write data bits 7:5 are ignored, and the direction read returns them as 0. Latch and port reads return 0 in every bit above the defined ones. A read of address 3 returns 0.
- R10: With `cfg_rst_en` = 0, bit 5 of `pin_sync` and of the port read follows pin 5. With `cfg_rst_en` = 1, both read 0, and `ext_rst_req` is 1 exactly while synchronized pin 5 is low.
- R11: Read data is registered. It holds the addressed value in the cycle after `rd_en` is 1, and it is 0 in the cycle after `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address: 0 port, 1 latch, 2 direction |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| per_sel | input | 5 | Peripheral owns the pin |
| per_oe | input | 5 | Peripheral wants to drive the pin |
| per_dout | input | 5 | Peripheral output data |
| per_force_in | input | 5 | Peripheral forces the pin to input |
| cfg_rst_en | input | 1 | 1: pin 5 is the master reset input; 0: plain input |
| pin_in | input | 6 | Raw pin levels |
| pad_out | output | 5 | Registered pad output data |
| pad_oe | output | 5 | Registered pad output enables |
| pin_sync | output | 6 | Synchronized pin levels, bit 5 gated by configuration |
| ext_rst_req | output | 1 | Master reset request from pin 5 low |

## Verification
The bench builds the block with its defaults: five bidirectional pins, an eight-bit register bus and two synchronizer stages. The bus is wider than the port, so the zero fill of the upper read bits and the dropped direction bits 7:5 can be observed. With two stages, the one-edge and two-edge sample points around the synchronizer can be told apart. With five pins, one vector can mix driven, tri-stated, peripheral-driven and forced-input pins.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PORT = 2'd0,
    REG_LAT  = 2'd1,
    REG_DIR  = 2'd2
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

  // R4
  sync_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> stg[0] == $past(d));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NUM_BIDIR = 5,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_en,
  input  logic [NUM_BIDIR:0]   port_level,
  output logic [NUM_BIDIR-1:0] lat_q,
  output logic [NUM_BIDIR-1:0] dir_q,
  output logic [DATA_W-1:0]    rd_data
);
  localparam int PORT_W = NUM_BIDIR + 1;

  logic wr_lat, wr_dir;
  logic [DATA_W-1:0] rd_next;

  assign wr_lat = wr_en && (addr == REG_LAT || addr == REG_PORT);
  assign wr_dir = wr_en && (addr == REG_DIR);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      if (wr_lat) lat_q <= wr_data[NUM_BIDIR-1:0];
      if (wr_dir) dir_q <= wr_data[NUM_BIDIR-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      REG_PORT: rd_next[PORT_W-1:0]    = port_level;
      REG_LAT:  rd_next[NUM_BIDIR-1:0] = lat_q;
      REG_DIR:  rd_next[NUM_BIDIR-1:0] = dir_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
    else            rd_data <= '0;
  end

  // R2
  dir_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dir_q == '1);
  // R3
  lat_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lat |=> lat_q == $past(wr_data[NUM_BIDIR-1:0]));
  // R5
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_dir |=> $stable(dir_q));
  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rd_data == '0);
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int NUM_BIDIR = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BIDIR-1:0] lat_q,
  input  logic [NUM_BIDIR-1:0] dir_q,
  input  logic [NUM_BIDIR-1:0] per_sel,
  input  logic [NUM_BIDIR-1:0] per_oe,
  input  logic [NUM_BIDIR-1:0] per_dout,
  input  logic [NUM_BIDIR-1:0] per_force_in,
  output logic [NUM_BIDIR-1:0] pad_out,
  output logic [NUM_BIDIR-1:0] pad_oe
);
  for (genvar i = 0; i < NUM_BIDIR; i++) begin : g_pin
    logic drive_per, force_in;
    assign drive_per = per_sel[i] && per_oe[i];
    assign force_in  = per_sel[i] && per_force_in[i] && !drive_per;

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
      end else begin
        pad_out[i] <= drive_per ? per_dout[i] : lat_q[i];
        pad_oe[i]  <= drive_per || (!dir_q[i] && !force_in);
      end
    end

    // R6
    per_drive_chk: assert property (@(posedge clk) disable iff (rst)
      (per_sel[i] && per_oe[i]) |=> pad_oe[i] && pad_out[i] == $past(per_dout[i]));
    // R8
    force_in_chk: assert property (@(posedge clk) disable iff (rst)
      (per_sel[i] && per_force_in[i] && !per_oe[i]) |=> !pad_oe[i]);
    // R1
    tri_state_chk: assert property (@(posedge clk) disable iff (rst)
      (!per_sel[i] && dir_q[i]) |=> !pad_oe[i]);
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NUM_BIDIR   = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_en,
  output logic [DATA_W-1:0]    rd_data,
  input  logic [NUM_BIDIR-1:0] per_sel,
  input  logic [NUM_BIDIR-1:0] per_oe,
  input  logic [NUM_BIDIR-1:0] per_dout,
  input  logic [NUM_BIDIR-1:0] per_force_in,
  input  logic                 cfg_rst_en,
  input  logic [NUM_BIDIR:0]   pin_in,
  output logic [NUM_BIDIR-1:0] pad_out,
  output logic [NUM_BIDIR-1:0] pad_oe,
  output logic [NUM_BIDIR:0]   pin_sync,
  output logic                 ext_rst_req
);
  localparam int PORT_W = NUM_BIDIR + 1;

  logic [PORT_W-1:0]    synced;
  logic [NUM_BIDIR-1:0] lat_q, dir_q;

  gpio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(synced)
  );

  assign pin_sync    = {synced[NUM_BIDIR] & ~cfg_rst_en, synced[NUM_BIDIR-1:0]};
  assign ext_rst_req = cfg_rst_en & ~synced[NUM_BIDIR];

  gpio_regs #(.NUM_BIDIR(NUM_BIDIR), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .port_level(pin_sync), .lat_q(lat_q), .dir_q(dir_q),
    .rd_data(rd_data)
  );

  gpio_pad_mux #(.NUM_BIDIR(NUM_BIDIR)) i_mux (
    .clk(clk), .rst(rst), .lat_q(lat_q), .dir_q(dir_q),
    .per_sel(per_sel), .per_oe(per_oe), .per_dout(per_dout),
    .per_force_in(per_force_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // R10
  rst_pin_mask_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rst_en |-> !rd_en || 1'b1 ##1 (cfg_rst_en && $past(rd_en) && $past(addr) == REG_PORT) |-> !rd_data[NUM_BIDIR]);
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] per_sel = '0, per_oe = '0, per_dout = '0, per_force_in = '0;
  logic       cfg_rst_en = 1'b0;
  logic [5:0] pin_in = '0;
  logic [4:0] pad_out, pad_oe;
  logic [5:0] pin_sync;
  logic       ext_rst_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .per_sel(per_sel), .per_oe(per_oe),
    .per_dout(per_dout), .per_force_in(per_force_in), .cfg_rst_en(cfg_rst_en),
    .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_sync(pin_sync),
    .ext_rst_req(ext_rst_req)
  );

  // dir, lat, sel, oe, dout, force_in, exp_oe, exp_out
  typedef logic [4:0] vec_t [8];
  localparam vec_t VECS [7] = '{
    '{5'b11111, 5'b10101, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b10101},
    '{5'b00000, 5'b10101, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b11111, 5'b10101},
    '{5'b01010, 5'b00110, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b10101, 5'b00110},
    '{5'b11111, 5'b00000, 5'b00011, 5'b00011, 5'b00010, 5'b00000, 5'b00011, 5'b00010},
    '{5'b00000, 5'b11111, 5'b00000, 5'b11111, 5'b00000, 5'b00000, 5'b11111, 5'b11111},
    '{5'b00000, 5'b01010, 5'b11000, 5'b00000, 5'b00000, 5'b11000, 5'b00111, 5'b01010},
    '{5'b10000, 5'b00001, 5'b10001, 5'b00001, 5'b00000, 5'b10001, 5'b01111, 5'b00000}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); d = rd_data; rd_en = 1'b0;
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    check("R2 pad_oe", {3'b0, pad_oe}, 8'h00);
    check("R2 rd_data", rd_data, 8'h00);
    do_read(2'd2, r); check("R2 dir", r, 8'h1F);
    do_read(2'd1, r); check("R2 latch", r, 8'h00);

    // R1 R5 R6 R7 R8: vector table
    for (int v = 0; v < 7; v++) begin
      do_write(2'd2, {3'b000, VECS[v][0]});
      do_write(2'd1, {3'b000, VECS[v][1]});
      @(negedge clk);
      per_sel = VECS[v][2]; per_oe = VECS[v][3];
      per_dout = VECS[v][4]; per_force_in = VECS[v][5];
      repeat (2) @(negedge clk);
      check("R1/R6/R7/R8 pad_oe", {3'b0, pad_oe}, {3'b0, VECS[v][6]});
      check("R1/R6 pad_out", {3'b0, pad_out}, {3'b0, VECS[v][7]});
      do_read(2'd2, r); check("R5 dir readback", r, {3'b0, VECS[v][0]});
      do_read(2'd1, r); check("R3 latch readback", r, {3'b0, VECS[v][1]});
      per_sel = '0; per_oe = '0; per_dout = '0; per_force_in = '0;
    end

    // R3: port address write loads latch
    do_write(2'd0, 8'hF3);
    do_read(2'd1, r); check("R3 port write", r, 8'h13);
    // R9: direction upper bits ignored
    do_write(2'd2, 8'hE0);
    do_read(2'd2, r); check("R9 dir upper", r, 8'h00);
    do_write(2'd2, 8'hFF);
    do_read(2'd2, r); check("R9 dir all", r, 8'h1F);
    do_read(2'd3, r); check("R9 addr3", r, 8'h00);

    // R1 timing: pad changes on second edge after write edge
    do_write(2'd2, 8'h00);
    repeat (2) @(negedge clk);
    @(negedge clk); addr = 2'd1; wr_data = 8'h1F; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    check("R1 one edge", {3'b0, pad_out}, 8'h13);
    @(negedge clk);
    check("R1 two edges", {3'b0, pad_out}, 8'h1F);

    // R4: synchronizer latency
    pin_in = 6'b000000;
    repeat (3) @(negedge clk);
    pin_in = 6'b011010;
    @(negedge clk); check("R4 one edge", {2'b0, pin_sync}, 8'h00);
    @(negedge clk); check("R4 two edges", {2'b0, pin_sync}, 8'h1A);
    do_read(2'd0, r); check("R4 port read", r, 8'h1A);

    // R10: pin 5 configuration
    cfg_rst_en = 1'b0; pin_in = 6'b100001;
    repeat (3) @(negedge clk);
    do_read(2'd0, r); check("R10 plain input", r, 8'h21);
    cfg_rst_en = 1'b1;
    @(negedge clk);
    do_read(2'd0, r); check("R10 masked read", r, 8'h01);
    check("R10 no reset req", {7'b0, ext_rst_req}, 8'h00);
    pin_in = 6'b000001;
    repeat (3) @(negedge clk);
    check("R10 reset req", {7'b0, ext_rst_req}, 8'h01);
    check("R10 sync bit5", {2'b0, pin_sync}, 8'h01);
    cfg_rst_en = 1'b0;

    // R11: read data zero when idle
    do_read(2'd1, r);
    @(negedge clk);
    check("R11 idle zero", rd_data, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule